// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a small memory-mapped I/O port with four pins. Software sets the level each pin drives through an output data register. A direction register chooses, pin by pin, whether the pin is driven or left high-impedance. A read-only pin-state view returns, for each bit, the driven value when the pin is an output and the synchronized external level when it is an input. Bus accesses use a plain synchronous register port: address, write strobe, read strobe, byte-wide write data and byte-wide read data registered one cycle after the strobe.

The block has four power controls. Power-on reset is synchronous and clears everything. Manual reset keeps the port configuration and clears only the read data. Hardware standby clears the configuration at once, without waiting for a clock. Software standby freezes every register in the block while it is asserted.

Top module: `gpio4_port`

## Requirements
- R1: While `por_i` is sampled high at a rising edge, the data register, the direction register, the input synchronizer and `rdata_o` are cleared. Afterwards `pin_o` and `pin_oe_o` are 0 and a pin-state read returns the pin levels.
- R2: A write to address 0 (output data) with `wr_i` high loads `wdata_i[3:0]` into the data register at that edge. A later read of address 0 returns that value in bits 3:0.
- R3: A write to address 1 (direction) loads `wdata_i[3:0]` into the direction register. The direction register is write-only: reads of address 1 return 0, and reads of the unmapped address 3 return 0.
- R4: `pin_o` always equals the data register and `pin_oe_o[i]` equals direction bit i, so a pin whose direction bit is 0 is high-impedance.
- R5: A read of address 2 (pin state) returns, for each bit i, data bit i when direction bit i is 1 and the synchronized level of `pin_i[i]` when it is 0.
- R6: External levels pass through a two-flop synchronizer. A level first sampled at rising edge k is returned by a pin-state read whose strobe is sampled at edge k+2 or later. A read whose strobe is sampled at edge k+1 still returns the earlier level.
- R7: `rdata_o` is loaded at the edge where `rd_i` is sampled high and holds its value until the next accepted read, even if the registers change in the meantime.
- R8: Bits 7:4 of `rdata_o` always read 0, and bits 7:4 of `wdata_i` are ignored on every write.
- R9: A write to address 2 or address 3 changes neither the data register nor the direction register.
- R10: While `mrst_i` is sampled high (and `por_i` is low), the data and direction registers keep their contents, writes are ignored, and `rdata_o` is cleared to 0.
- R11: Raising `hwstby_i` clears the data and direction registers immediately, without a clock edge. While it stays high, writes have no effect.
- R12: While `swstby_i` is sampled high, writes and reads are ignored, `rdata_o` holds, and the synchronizer holds its last level. The first pin-state read accepted after release therefore returns the level frozen on entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| mrst_i | input | 1 | Manual reset, synchronous, active high |
| hwstby_i | input | 1 | Hardware standby, asynchronous clear of configuration |
| swstby_i | input | 1 | Software standby, freezes all registers |
| addr_i | input | 2 | Register address: 0 data, 1 direction, 2 pin state, 3 unmapped |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data, bits 3:0 used |
| rdata_o | output | 8 | Read data, valid the cycle after an accepted read |
| pin_i | input | 4 | External pin levels |
| pin_o | output | 4 | Pin output values |
| pin_oe_o | output | 4 | Pin output enables, high drives the pin |

## Verification
A write lands one edge after its strobe, so the bench samples `pin_o` and `pin_oe_o` on the falling edge that follows the write cycle. Read data appears one edge after the read strobe, and the bench takes it on the next falling edge. A pin change needs two edges to cross the synchronizer before a read edge can capture it, so every pin-state read is issued at least two cycles after the pins are set. The latency test sets up both sides of that boundary: it checks the read captured at the first edge after the crossing for the old level and the read at the next edge for the new one. Hardware standby is raised between edges and checked before the next edge, which proves the clear does not wait for a clock.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;

    localparam int PORT_W     = 4;
    localparam int BUS_W      = 8;
    localparam int ADDR_W     = 2;
    localparam int SYNC_DEPTH = 2;
    localparam int RSVD_W     = BUS_W - PORT_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
    } port_cfg_t;

    function automatic logic [BUS_W-1:0] widen(input logic [PORT_W-1:0] v);
        return {{RSVD_W{1'b0}}, v};
    endfunction

    function automatic logic sel_is_cfg(input reg_sel_e s);
        return (s == SEL_DATA) || (s == SEL_DIR);
    endfunction

endpackage

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 por_i,
    input  logic                 mrst_i,
    input  logic                 hwstby_i,
    input  logic                 swstby_i,
    input  logic                 wr_i,
    input  reg_sel_e             sel_i,
    input  logic [PORT_W-1:0]    wdata_i,
    output port_cfg_t            cfg_o
);

    port_cfg_t cfg_q;
    logic      wr_ok;

    assign wr_ok = wr_i && !swstby_i && !mrst_i && sel_is_cfg(sel_i);

    always_ff @(posedge clk_i or posedge hwstby_i) begin
        if (hwstby_i) begin
            cfg_q <= '0;
        end else if (por_i) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            case (sel_i)
                SEL_DATA: cfg_q.data <= wdata_i;
                SEL_DIR:  cfg_q.dir  <= wdata_i;
                default:  cfg_q      <= cfg_q;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R1
    por_clear_chk: assert property (@(posedge clk_i) disable iff (hwstby_i)
        por_i |=> (cfg_q == '0));

    // R2
    data_load_chk: assert property (@(posedge clk_i) disable iff (por_i || hwstby_i)
        (wr_i && !swstby_i && !mrst_i && sel_i == SEL_DATA) |=> (cfg_q.data == $past(wdata_i)));

    // R9
    ro_addr_chk: assert property (@(posedge clk_i) disable iff (por_i || hwstby_i)
        (wr_i && (sel_i == SEL_PINS || sel_i == SEL_NONE)) |=> $stable(cfg_q));

    // R10
    mrst_keep_chk: assert property (@(posedge clk_i) disable iff (por_i || hwstby_i)
        mrst_i |=> $stable(cfg_q));

    // R11
    hwstby_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
        hwstby_i |-> (cfg_q == '0));

    // R12
    swstby_freeze_chk: assert property (@(posedge clk_i) disable iff (por_i || hwstby_i)
        swstby_i |=> $stable(cfg_q));

endmodule

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int N     = gpio4_pkg::PORT_W,
    parameter int DEPTH = gpio4_pkg::SYNC_DEPTH
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic         hold_i,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o
);

    logic [N-1:0] stage_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (por_i)        stage_q[s] <= '0;
                else if (!hold_i) stage_q[s] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (por_i)        stage_q[s] <= '0;
                else if (!hold_i) stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign level_o = stage_q[DEPTH-1];

    // R12
    sync_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        hold_i |=> $stable(level_o));

    if (DEPTH == 2) begin : g_two_chk
        // R6
        sync_delay_chk: assert property (@(posedge clk_i) disable iff (por_i)
            (!hold_i && !$past(hold_i) && !$past(por_i)) |=> (level_o == $past(pin_i, 2)));
    end

endmodule

// File: rtl/gpio4_rdmux.sv
module gpio4_rdmux
    import gpio4_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              mrst_i,
    input  logic              swstby_i,
    input  logic              rd_i,
    input  reg_sel_e          sel_i,
    input  port_cfg_t         cfg_i,
    input  logic [PORT_W-1:0] level_i,
    output logic [BUS_W-1:0]  rdata_o
);

    logic [PORT_W-1:0] view;
    logic [BUS_W-1:0]  word;
    logic [BUS_W-1:0]  rdata_q;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        assign view[i] = cfg_i.dir[i] ? cfg_i.data[i] : level_i[i];
    end

    always_comb begin
        case (sel_i)
            SEL_DATA: word = widen(cfg_i.data);
            SEL_PINS: word = widen(view);
            default:  word = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (por_i || mrst_i)       rdata_q <= '0;
        else if (rd_i && !swstby_i) rdata_q <= word;
    end

    assign rdata_o = rdata_q;

    // R7
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (!(rd_i && !swstby_i) && !mrst_i) |=> $stable(rdata_o));

    // R3
    dir_wo_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (rd_i && (sel_i == SEL_DIR || sel_i == SEL_NONE)) |=> (rdata_o == '0));

    // R5
    out_bits_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (rd_i && !swstby_i && !mrst_i && sel_i == SEL_PINS)
        |=> (((rdata_o[PORT_W-1:0] ^ $past(cfg_i.data)) & $past(cfg_i.dir)) == '0));

    // R10
    mrst_rd_chk: assert property (@(posedge clk_i) disable iff (por_i)
        mrst_i |=> (rdata_o == '0));

endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio4_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              mrst_i,
    input  logic              hwstby_i,
    input  logic              swstby_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe_o
);

    reg_sel_e          sel;
    port_cfg_t         cfg;
    logic [PORT_W-1:0] level;
    logic              unused_rsvd_wdata;

    assign sel               = reg_sel_e'(addr_i);
    assign unused_rsvd_wdata = ^wdata_i[BUS_W-1:PORT_W];

    gpio4_regs i_regs (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .mrst_i   (mrst_i),
        .hwstby_i (hwstby_i),
        .swstby_i (swstby_i),
        .wr_i     (wr_i),
        .sel_i    (sel),
        .wdata_i  (wdata_i[PORT_W-1:0]),
        .cfg_o    (cfg)
    );

    gpio4_sync #(
        .N     (PORT_W),
        .DEPTH (SYNC_DEPTH)
    ) i_sync (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .hold_i  (swstby_i),
        .pin_i   (pin_i),
        .level_o (level)
    );

    gpio4_rdmux i_rdmux (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .mrst_i   (mrst_i),
        .swstby_i (swstby_i),
        .rd_i     (rd_i),
        .sel_i    (sel),
        .cfg_i    (cfg),
        .level_i  (level),
        .rdata_o  (rdata_o)
    );

    assign pin_o    = cfg.data;
    assign pin_oe_o = cfg.dir;

    // R8
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (por_i)
        rdata_o[BUS_W-1:PORT_W] == '0);

    // R4
    hiz_idle_chk: assert property (@(posedge clk_i) disable iff (por_i || hwstby_i)
        (wr_i && !swstby_i && !mrst_i && sel == SEL_DIR) |=> (pin_oe_o == $past(wdata_i[PORT_W-1:0])));

endmodule

// File: tb/test_gpio4_port.sv
module test_gpio4_port;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       mrst = 1'b0;
    logic       hwstby = 1'b0;
    logic       swstby = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] pins = 4'h0;
    logic [3:0] pin_o;
    logic [3:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio4_port i_gpio4_port (
        .clk_i    (clk),
        .por_i    (por),
        .mrst_i   (mrst),
        .hwstby_i (hwstby),
        .swstby_i (swstby),
        .addr_i   (addr),
        .wr_i     (wr),
        .rd_i     (rd),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .pin_i    (pins),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        por = 1'b0;
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 pin_o", {4'h0, pin_o}, 8'h00);
        check("R1 oe", {4'h0, pin_oe}, 8'h00);

        // R2 R4 R5 R8 sweep: every data, direction and pin pattern
        for (int d = 0; d < 16; d++) begin
            for (int r = 0; r < 16; r++) begin
                do_write(2'd0, {4'(d ^ r ^ 5), 4'(d)});
                do_write(2'd1, {4'(~r), 4'(r)});
                check("R4 pin_o", {4'h0, pin_o}, 8'(d));
                check("R4 oe", {4'h0, pin_oe}, 8'(r));
                do_read(2'd0, v);
                check("R2/R8 data read", v, 8'(d));
                for (int p = 0; p < 16; p++) begin
                    pins = 4'(p);
                    repeat (2) @(negedge clk);
                    do_read(2'd2, v);
                    check("R5 pin-state read", v, 8'((d & r) | (p & ~r)));
                end
            end
        end

        // R3 direction write-only, unmapped address
        do_write(2'd1, 8'hA5);
        check("R3 oe", {4'h0, pin_oe}, 8'h05);
        do_read(2'd1, v);
        check("R3 dir read", v, 8'h00);
        do_read(2'd3, v);
        check("R3 unmapped read", v, 8'h00);

        // R9 writes to read-only and unmapped addresses
        do_write(2'd0, 8'h03);
        do_write(2'd1, 8'h0C);
        do_write(2'd2, 8'hFF);
        do_write(2'd3, 8'hFF);
        check("R9 pin_o", {4'h0, pin_o}, 8'h03);
        check("R9 oe", {4'h0, pin_oe}, 8'h0C);

        // R6 synchronizer latency boundary
        do_write(2'd1, 8'h00);
        pins = 4'h0;
        repeat (3) @(negedge clk);
        pins = 4'hF;
        @(negedge clk);
        addr = 2'd2; rd = 1'b1;
        @(negedge clk);
        check("R6 read one edge late", rdata, 8'h00);
        @(negedge clk);
        check("R6 read two edges late", rdata, 8'h0F);
        rd = 1'b0;

        // R7 read data holds between reads
        do_write(2'd0, 8'h06);
        do_read(2'd0, v);
        do_write(2'd0, 8'h09);
        repeat (3) @(negedge clk);
        check("R7 hold", rdata, 8'h06);

        // R10 manual reset keeps configuration, clears read data
        do_write(2'd1, 8'h06);
        do_read(2'd0, v);
        check("R10 pre read", v, 8'h09);
        @(negedge clk);
        mrst = 1'b1; addr = 2'd0; wdata = 8'h00; wr = 1'b1;
        @(negedge clk);
        mrst = 1'b0; wr = 1'b0;
        check("R10 rdata cleared", rdata, 8'h00);
        check("R10 pin_o kept", {4'h0, pin_o}, 8'h09);
        check("R10 oe kept", {4'h0, pin_oe}, 8'h06);
        do_read(2'd0, v);
        check("R10 data read", v, 8'h09);

        // R11 hardware standby clears without a clock edge
        do_write(2'd0, 8'h0A);
        do_write(2'd1, 8'h0F);
        #2 hwstby = 1'b1;
        #1;
        check("R11 async pin_o", {4'h0, pin_o}, 8'h00);
        check("R11 async oe", {4'h0, pin_oe}, 8'h00);
        do_write(2'd0, 8'h07);
        check("R11 write ignored", {4'h0, pin_o}, 8'h00);
        hwstby = 1'b0;
        do_read(2'd0, v);
        check("R11 data after", v, 8'h00);

        // R12 software standby freezes everything
        do_write(2'd0, 8'h05);
        pins = 4'h3;
        repeat (3) @(negedge clk);
        do_read(2'd0, v);
        swstby = 1'b1;
        do_write(2'd0, 8'h0A);
        do_write(2'd1, 8'h0F);
        check("R12 pin_o frozen", {4'h0, pin_o}, 8'h05);
        check("R12 oe frozen", {4'h0, pin_oe}, 8'h00);
        do_read(2'd2, v);
        check("R12 rdata held", v, 8'h05);
        pins = 4'hC;
        repeat (3) @(negedge clk);
        swstby = 1'b0; addr = 2'd2; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R12 sync frozen", rdata, 8'h03);
        repeat (2) @(negedge clk);
        do_read(2'd2, v);
        check("R12 sync resumes", v, 8'h0C);

        // R1 power-on reset mid-run
        do_write(2'd1, 8'h0B);
        do_read(2'd0, v);
        @(negedge clk);
        por = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0;
        check("R1 late pin_o", {4'h0, pin_o}, 8'h00);
        check("R1 late oe", {4'h0, pin_oe}, 8'h00);
        check("R1 late rdata", rdata, 8'h00);
        repeat (2) @(negedge clk);
        do_read(2'd2, v);
        check("R1 pins visible", v, 8'h0C);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule